// File: doc/BRIEF.md
# Two-Wire Addressed Serial Slave

This block is the bus-facing end of a small addressable device on a two-wire serial bus with one clock line and one open-drain data line. A fast system clock oversamples both lines. The block recognises start and stop conditions and receives an address byte. It compares the address with a fixed prefix and with strap pins, and it acknowledges only when both match. After that it either hands every received data byte to a command unit, or it sends bytes that the command unit provides.

The block takes two control inputs from the command unit. The first is a busy flag, raised while a nonvolatile programming cycle runs. While it is high the block leaves its own address unacknowledged, so the host can poll until the device answers again. The second is a refusal flag. It withholds the acknowledge of a data byte, which is how write protection is reported to the host.

The address byte carries a 7-bit slave address followed by a direction bit. The upper four address bits are a fixed prefix, 0101 by default. The lower three address bits come from strap pins.

Top module: `tws_slave`

## Requirements
- R1: Before a start condition (data line falling while the clock line is high), the block ignores all clock and data activity. It drives no acknowledge and produces no strobes.
- R2: The address byte arrives MSB first. Bits 7:4 must equal the prefix 0101, and bits 3:1 must equal `strapAddr[2:0]`. On a match the block pulls SDA low (`sdaOe`=1) for the ninth clock. Bit 0 selects the direction: 1 means read.
- R3: On a mismatched address the block gives no acknowledge. It then ignores the bus until the next start, and it emits no `rxValid` for the bytes that follow.
- R4: When `busyIn` is high as the address byte completes, the block leaves even a matching address unacknowledged and ignores the rest of the transfer.
- R5: In write mode each received data byte appears on `rxByte` with a one-cycle `rxValid` pulse after its eighth bit. The byte is then acknowledged.
- R6: When `refuseData` is high after the eighth bit of a data byte, the block does not acknowledge that byte. It still strobes `rxValid` for it, and it ignores all later bytes until a stop or start.
- R7: In read mode the block sends `txByte` MSB first. The byte is captured when each transmission begins, and each capture is marked by a one-cycle `txReq` pulse.
- R8: After each byte sent, a master acknowledge (SDA low on the ninth clock) makes the block load and send the next byte. A missing acknowledge makes it release SDA and stay silent until a stop or start.
- R9: A start condition seen in the middle of a transfer restarts address reception.
- R10: `sdaOe` changes only while the synchronised clock line is low.
- R11: After reset `sdaOe`, `rxValid` and `txReq` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line as seen at the pin |
| sdaIn | input | 1 | Bus data line as seen at the pin |
| sdaOe | output | 1 | 1 pulls SDA low, 0 releases it |
| strapAddr | input | 3 | Strap pins forming the low address bits |
| busyIn | input | 1 | Nonvolatile programming in progress |
| refuseData | input | 1 | Withhold the acknowledge of the current data byte |
| rxByte | output | 8 | Last received data byte |
| rxValid | output | 1 | One-cycle strobe: `rxByte` holds a new byte |
| txByte | input | 8 | Next byte to send in read mode |
| txReq | output | 1 | One-cycle strobe: `txByte` was captured |

## Verification
The bench sends clock pulses with data before any start condition; a block that shifted them in would acknowledge a phantom address. It varies the address prefix and the strap bits separately, and it raises busy during a matching address; getting these wrong shows up as an acknowledge on a foreign address, or as an answer during programming that would end acknowledge polling too early. It refuses one byte and then sends another; a block that only dropped one acknowledge would accept the second byte. In read mode it ends with a missing master acknowledge followed by an extra byte time, which catches a transmitter that keeps driving data onto the bus.

// File: rtl/tws_pkg.sv
package tws_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_WR_DATA, ST_WR_ACK,
    ST_RD_DATA, ST_RD_ACK, ST_RD_LOAD, ST_WAIT_STOP
  } tws_state_t;

  typedef struct packed {
    logic clrCnt;
    logic shiftIn;
    logic shiftOut;
    logic loadTx;
    logic ackDrive;
    logic relBus;
  } tws_strobe_t;
endpackage

// File: rtl/tws_sync.sv
module tws_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclS,
  output logic sdaS,
  output logic sclRise,
  output logic sclFall,
  output logic startDet,
  output logic stopDet
);
  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  logic sclD, sdaD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclD    <= 1'b1;
      sdaD    <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
      sclD    <= sclS;
      sdaD    <= sdaS;
    end
  end

  assign sclS     = sclPipe[SYNC_STAGES-1];
  assign sdaS     = sdaPipe[SYNC_STAGES-1];
  assign sclRise  = sclS & ~sclD;
  assign sclFall  = ~sclS & sclD;
  assign startDet = sclS & sclD & sdaD & ~sdaS;
  assign stopDet  = sclS & sclD & ~sdaD & sdaS;
endmodule

// File: rtl/tws_datapath.sv
module tws_datapath
  import tws_pkg::*;
#(
  parameter int            BYTE_W   = 8,
  parameter int            PREFIX_W = 4,
  parameter logic [3:0]    PREFIX   = 4'b0101,
  parameter int            STRAP_W  = BYTE_W - 1 - PREFIX_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  tws_strobe_t        stb,
  input  logic               sclS,
  input  logic               sdaS,
  input  logic [STRAP_W-1:0] strapAddr,
  input  logic [BYTE_W-1:0]  txByte,
  output logic [BYTE_W-1:0]  rxByte,
  output logic               byteFull,
  output logic               cntLast,
  output logic               addrHit,
  output logic               rwBit,
  output logic               sdaOe
);
  localparam int CNT_W = $clog2(BYTE_W + 1);

  logic [CNT_W-1:0]  bitCnt;
  logic [BYTE_W-1:0] rxShift, txShift;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt  <= '0;
      rxShift <= '0;
      txShift <= '0;
      sdaOe   <= 1'b0;
    end else begin
      if (stb.clrCnt || stb.loadTx)
        bitCnt <= '0;
      else if (stb.shiftIn || stb.shiftOut)
        bitCnt <= bitCnt + 1'b1;

      if (stb.shiftIn)
        rxShift <= {rxShift[BYTE_W-2:0], sdaS};

      if (stb.loadTx)
        txShift <= txByte;
      else if (stb.shiftOut)
        txShift <= txShift << 1;

      if (stb.relBus)
        sdaOe <= 1'b0;
      else if (stb.ackDrive)
        sdaOe <= 1'b1;
      else if (stb.loadTx)
        sdaOe <= ~txByte[BYTE_W-1];
      else if (stb.shiftOut)
        sdaOe <= ~txShift[BYTE_W-2];
    end
  end

  assign rxByte   = rxShift;
  assign byteFull = (bitCnt == CNT_W'(BYTE_W));
  assign cntLast  = (bitCnt == CNT_W'(BYTE_W - 1));
  assign addrHit  = (rxShift[BYTE_W-1 -: PREFIX_W] == PREFIX[PREFIX_W-1:0]) &&
                    (rxShift[STRAP_W:1] == strapAddr);
  assign rwBit    = rxShift[0];

  // R10
  oe_clk_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sclS && $past(sclS)) |-> $stable(sdaOe));

  // R2
  ack_pull_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.ackDrive && !stb.relBus) |=> sdaOe);
endmodule

// File: rtl/tws_ctrl.sv
module tws_ctrl
  import tws_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        sdaS,
  input  logic        sclRise,
  input  logic        sclFall,
  input  logic        startDet,
  input  logic        stopDet,
  input  logic        byteFull,
  input  logic        cntLast,
  input  logic        addrHit,
  input  logic        rwBit,
  input  logic        busyIn,
  input  logic        refuseData,
  output tws_strobe_t stb,
  output logic        rxValid,
  output logic        txReq
);
  tws_state_t state, nextState;
  logic rwReg, rwNext, rxValidD, txReqD;

  always_comb begin
    stb       = '0;
    nextState = state;
    rwNext    = rwReg;
    rxValidD  = 1'b0;
    txReqD    = 1'b0;
    if (startDet) begin
      nextState  = ST_ADDR;
      stb.clrCnt = 1'b1;
      stb.relBus = 1'b1;
    end else if (stopDet) begin
      nextState  = ST_IDLE;
      stb.relBus = 1'b1;
    end else begin
      unique case (state)
        ST_ADDR: begin
          if (sclRise && !byteFull) stb.shiftIn = 1'b1;
          if (sclFall && byteFull) begin
            if (addrHit && !busyIn) begin
              stb.ackDrive = 1'b1;
              rwNext       = rwBit;
              nextState    = ST_ADDR_ACK;
            end else begin
              stb.relBus = 1'b1;
              nextState  = ST_IDLE;
            end
          end
        end
        ST_ADDR_ACK: if (sclFall) begin
          if (rwReg) begin
            stb.loadTx = 1'b1;
            txReqD     = 1'b1;
            nextState  = ST_RD_DATA;
          end else begin
            stb.relBus = 1'b1;
            stb.clrCnt = 1'b1;
            nextState  = ST_WR_DATA;
          end
        end
        ST_WR_DATA: begin
          if (sclRise && !byteFull) begin
            stb.shiftIn = 1'b1;
            rxValidD    = cntLast;
          end
          if (sclFall && byteFull) begin
            if (!refuseData) begin
              stb.ackDrive = 1'b1;
              nextState    = ST_WR_ACK;
            end else begin
              nextState = ST_WAIT_STOP;
            end
          end
        end
        ST_WR_ACK: if (sclFall) begin
          stb.relBus = 1'b1;
          stb.clrCnt = 1'b1;
          nextState  = ST_WR_DATA;
        end
        ST_RD_DATA: if (sclFall) begin
          if (cntLast) begin
            stb.relBus = 1'b1;
            nextState  = ST_RD_ACK;
          end else begin
            stb.shiftOut = 1'b1;
          end
        end
        ST_RD_ACK: if (sclRise) nextState = sdaS ? ST_WAIT_STOP : ST_RD_LOAD;
        ST_RD_LOAD: if (sclFall) begin
          stb.loadTx = 1'b1;
          txReqD     = 1'b1;
          nextState  = ST_RD_DATA;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      rwReg   <= 1'b0;
      rxValid <= 1'b0;
      txReq   <= 1'b0;
    end else begin
      state   <= nextState;
      rwReg   <= rwNext;
      rxValid <= rxValidD;
      txReq   <= txReqD;
    end
  end

  // R5
  rx_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

  // R3
  mismatch_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ADDR && sclFall && byteFull && !addrHit && !startDet && !stopDet)
      |=> (state == ST_IDLE));

  // R4
  busy_silent_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ADDR && sclFall && byteFull && busyIn && !startDet && !stopDet)
      |=> (state == ST_IDLE));

  // R6
  refuse_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WR_DATA && sclFall && byteFull && refuseData && !startDet && !stopDet)
      |=> (state == ST_WAIT_STOP));

  // R8
  nack_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RD_ACK && sclRise && sdaS && !startDet && !stopDet)
      |=> (state == ST_WAIT_STOP));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> !(stb.shiftIn || stb.ackDrive || stb.loadTx));
endmodule

// File: rtl/tws_slave.sv
module tws_slave
  import tws_pkg::*;
#(
  parameter int         BYTE_W      = 8,
  parameter int         PREFIX_W    = 4,
  parameter logic [3:0] PREFIX      = 4'b0101,
  parameter int         STRAP_W     = BYTE_W - 1 - PREFIX_W,
  parameter int         SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sclIn,
  input  logic               sdaIn,
  output logic               sdaOe,
  input  logic [STRAP_W-1:0] strapAddr,
  input  logic               busyIn,
  input  logic               refuseData,
  output logic [BYTE_W-1:0]  rxByte,
  output logic               rxValid,
  input  logic [BYTE_W-1:0]  txByte,
  output logic               txReq
);
  logic sclS, sdaS, sclRise, sclFall, startDet, stopDet;
  logic byteFull, cntLast, addrHit, rwBit;
  tws_strobe_t stb;

  tws_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclS(sclS), .sdaS(sdaS), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet)
  );

  tws_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .sdaS(sdaS), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet), .byteFull(byteFull), .cntLast(cntLast),
    .addrHit(addrHit), .rwBit(rwBit), .busyIn(busyIn), .refuseData(refuseData),
    .stb(stb), .rxValid(rxValid), .txReq(txReq)
  );

  tws_datapath #(
    .BYTE_W(BYTE_W), .PREFIX_W(PREFIX_W), .PREFIX(PREFIX), .STRAP_W(STRAP_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .sclS(sclS), .sdaS(sdaS),
    .strapAddr(strapAddr), .txByte(txByte), .rxByte(rxByte),
    .byteFull(byteFull), .cntLast(cntLast), .addrHit(addrHit),
    .rwBit(rwBit), .sdaOe(sdaOe)
  );
endmodule

// File: tb/tws_slave_tb.sv
`timescale 1ns/1ps
module tws_slave_tb;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mScl = 1'b1, mSda = 1'b1;
  logic busyIn = 1'b0, refuseData = 1'b0;
  logic [2:0] strapAddr = 3'b101;
  logic [7:0] txByte = 8'hC3;
  logic [7:0] rxByte;
  logic sdaOe, rxValid, txReq;
  wire  sdaBus = mSda & ~sdaOe;

  int checks = 0, failures = 0;
  int rxCount = 0, txCount = 0, oeViol = 0, sclHigh = 0;
  logic [7:0] lastRx = 8'h00;
  logic prevOe = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tws_slave u_dut (
    .clk(clk), .rstN(rstN), .sclIn(mScl), .sdaIn(sdaBus), .sdaOe(sdaOe),
    .strapAddr(strapAddr), .busyIn(busyIn), .refuseData(refuseData),
    .rxByte(rxByte), .rxValid(rxValid), .txByte(txByte), .txReq(txReq)
  );

  // command-unit model and bus monitors
  always @(negedge clk) begin
    if (rxValid) begin rxCount++; lastRx = rxByte; end
    if (txReq) begin txCount++; txByte = txByte + 8'h11; end
    if (rstN && sclHigh >= 4 && sdaOe != prevOe) oeViol++;
    sclHigh = mScl ? sclHigh + 1 : 0;
    prevOe = sdaOe;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic q(); repeat (Q) @(negedge clk); endtask
  task automatic startCond(); mSda = 1; q(); mScl = 1; q(); mSda = 0; q(); mScl = 0; q(); endtask
  task automatic stopCond(); mSda = 0; q(); mScl = 1; q(); mSda = 1; q(); endtask
  task automatic sendBit(input logic b); mSda = b; q(); mScl = 1; q(); q(); mScl = 0; q(); endtask
  task automatic readBit(output logic b); mSda = 1; q(); mScl = 1; q(); b = sdaBus; q(); mScl = 0; q(); endtask
  task automatic sendByte(input logic [7:0] d, output logic ack);
    logic nb;
    for (int i = 7; i >= 0; i--) sendBit(d[i]);
    readBit(nb);
    ack = ~nb;
  endtask
  task automatic recvByte(output logic [7:0] d, input logic ackIt);
    for (int i = 7; i >= 0; i--) readBit(d[i]);
    sendBit(~ackIt);
  endtask

  // addr, data, busy, refuse, expAddrAck, expDataAck
  localparam logic [19:0] VECS [6] = '{
    {8'h5A, 8'h3C, 1'b0, 1'b0, 1'b1, 1'b1},
    {8'h5A, 8'hA5, 1'b0, 1'b1, 1'b1, 1'b0},
    {8'h5C, 8'h77, 1'b0, 1'b0, 1'b0, 1'b0},
    {8'hDA, 8'h11, 1'b0, 1'b0, 1'b0, 1'b0},
    {8'h5A, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0},
    {8'h5A, 8'hFF, 1'b0, 1'b0, 1'b1, 1'b1}
  };

  logic [19:0] v;
  logic ack, b;
  logic [7:0] d;
  int rxBefore, txBefore;

  initial begin
    repeat (5) @(negedge clk);
    // R11 reset state
    chk(sdaOe == 0, "R11 sdaOe", int'(sdaOe), 0);
    chk(rxValid == 0 && txReq == 0, "R11 strobes", int'({rxValid, txReq}), 0);
    rstN = 1'b1;
    q();

    // R1 activity before any start is ignored
    mScl = 0; q();
    for (int i = 7; i >= 0; i--) sendBit(8'h5A >> i);
    readBit(b);
    chk(b == 1'b1, "R1 no ack without start", int'(b), 1);
    sendByte(8'h42, ack);
    chk(rxCount == 0, "R1 no strobe without start", rxCount, 0);
    stopCond();

    // vector table: R2 R3 R4 R5 R6
    for (int i = 0; i < 6; i++) begin
      v = VECS[i];
      busyIn = v[3]; refuseData = v[2];
      rxBefore = rxCount;
      startCond();
      sendByte(v[19:12], ack);
      chk(ack == v[1], "R2/R3/R4 address ack", int'(ack), int'(v[1]));
      busyIn = 1'b0;
      sendByte(v[11:4], ack);
      chk(ack == v[0], "R5/R6 data ack", int'(ack), int'(v[0]));
      chk(rxCount == rxBefore + int'(v[1]), "R5 rxValid count", rxCount, rxBefore + int'(v[1]));
      if (v[1]) chk(lastRx == v[11:4], "R5 rxByte", int'(lastRx), int'(v[11:4]));
      refuseData = 1'b0;
      stopCond();
    end

    // R6 refused byte, later byte ignored
    rxBefore = rxCount;
    startCond();
    sendByte(8'h5A, ack);
    refuseData = 1'b1;
    sendByte(8'h55, ack);
    chk(ack == 0, "R6 refused byte not acked", int'(ack), 0);
    refuseData = 1'b0;
    sendByte(8'h66, ack);
    chk(ack == 0, "R6 later byte ignored", int'(ack), 0);
    chk(rxCount == rxBefore + 1, "R6 single strobe", rxCount, rxBefore + 1);
    stopCond();

    // R9 repeated start restarts address reception
    rxBefore = rxCount;
    startCond();
    sendByte(8'h5A, ack);
    sendByte(8'h12, ack);
    startCond();
    sendByte(8'h5A, ack);
    chk(ack == 1, "R9 address after repeated start", int'(ack), 1);
    sendByte(8'h34, ack);
    chk(ack == 1 && lastRx == 8'h34, "R9 data after repeated start", int'(lastRx), 8'h34);
    chk(rxCount == rxBefore + 2, "R9 strobe count", rxCount, rxBefore + 2);
    stopCond();

    // R7 R8 read mode
    txBefore = txCount;
    startCond();
    sendByte(8'h5B, ack);
    chk(ack == 1, "R2 read address ack", int'(ack), 1);
    recvByte(d, 1'b1);
    chk(d == 8'hC3, "R7 first read byte", int'(d), 8'hC3);
    recvByte(d, 1'b0);
    chk(d == 8'hD4, "R8 byte after master ack", int'(d), 8'hD4);
    recvByte(d, 1'b0);
    chk(d == 8'hFF, "R8 released after nack", int'(d), 8'hFF);
    chk(txCount == txBefore + 2, "R7 txReq count", txCount, txBefore + 2);
    stopCond();

    // R10 sdaOe stable while clock high
    chk(oeViol == 0, "R10 sdaOe change with SCL high", oeViol, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule